// File: doc/BRIEF.md
# Dual-Reload PWM Timer Bank

The block contains eight independent down-counting timers behind a small register interface, which has separate write and read strobes and a shared byte address. Each timer has two reload values. In PWM mode the timer's output starts low. The output changes level every time the count passes zero, and each change loads the reload value for the next phase. Because every phase lasts at least one clock, the waveform never sits at 0 % or 100 % duty.

Outside PWM mode a timer works as a plain interval counter. It either reloads from its low-phase value or wraps around to all ones. Every expiry sets a sticky raw interrupt bit for that timer. A per-timer mask gates that bit into the masked status and into the single `irq` line. Reading an end-of-interrupt location clears one bit or all of them. Read data appears on `rdata` one cycle after `rd_en`.

Top module: `pwm_timer_bank`

## Requirements
- R1: While `rst_n` is low, and directly after it is released, `pwm_out` and `irq` are 0 and every register reads 0.
- R2: When a control write turns the enable bit from 0 to 1, the counter loads the low-phase reload value L and the output goes low in that same cycle. The low phase lasts L+1 clocks.
- R3: In PWM mode the high phase lasts H+1 clocks, where H is the high-phase reload value, and the two phases alternate. With L=H=0 the output changes level on every clock.
- R4: With PWM off and the mode bit set (user reload), the counter runs L, L-1, ..., 0 and then reloads L. The live count can be read at timer offset +0x04.
- R5: With PWM off and the mode bit clear (free-running), the counter wraps from 0 to 0xFFFFFFFF instead of reloading. A timer in PWM mode always reloads, whatever the mode bit.
- R6: Clearing the enable bit holds the output low and freezes the counter.
- R7: Each expiry sets the raw bit of its timer. Raw status reads at 0xA8, with timer n in bit n. The masked status is raw AND NOT mask. It reads at 0xA0 (bit n) and at timer offset +0x10 (bit 0). `irq` is the OR of the masked bits.
- R8: A read of timer offset +0x0C returns 0 and clears that timer's raw bit. If an expiry lands in the same cycle, the bit stays set.
- R9: A read of 0xA4 returns 0 and clears every raw bit.
- R10: 0xAC reads the constant 0x50540102. Writes to 0xA0-0xAC, to the count offset and to unmapped addresses change nothing.
- R11: A reload value written while the timer runs is used at the next reload.
- R12: Timer n sits at base 0x14·n. The low-phase reload is at +0x00 and the control register at +0x08. The high-phase reload is at 0xB0+4·n. Control bits: 0 enable, 1 mode, 2 interrupt mask, 3 PWM. Only these four bits are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; clear-on-read side effects act on it |
| addr | input | AW | Byte address |
| wdata | input | CW | Write data |
| rdata | output | CW | Read data, valid the cycle after `rd_en` |
| pwm_out | output | NTMR | One waveform per timer |
| irq | output | 1 | OR of masked interrupt bits |

## Verification
Two events can fall on the same clock: an end-of-interrupt read clearing a raw bit, and that timer's expiry setting it. The bench provokes this by running a timer with both reloads at zero, so it expires on every clock, and issuing the per-timer clear read while it runs. The raw status read in the next cycle must still show the bit set, because the expiry has priority over the clear.

// File: rtl/pwm_timer_bank.sv
module pwm_timer_bank #(
  parameter int NTMR = 8,
  parameter int CW = 32,
  parameter int AW = 8,
  parameter logic [CW-1:0] VERSION = 32'h5054_0102
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [CW-1:0]   wdata,
  output logic [CW-1:0]   rdata,
  output logic [NTMR-1:0] pwm_out,
  output logic            irq
);
  localparam int STRIDE   = 'h14;
  localparam int HI_BASE  = 'hB0;
  localparam int A_ISTS   = 'hA0;
  localparam int A_EOI    = 'hA4;
  localparam int A_RAW    = 'hA8;
  localparam int A_VER    = 'hAC;
  localparam int CTLW     = 4;

  logic [NTMR-1:0][CW-1:0]   ld_lo, ld_hi, cnt;
  logic [NTMR-1:0][CTLW-1:0] ctrl;
  logic [NTMR-1:0] phase, raw, masked, expire;
  logic [NTMR-1:0] en_v, mode_v, msk_v, pwm_v;
  logic [NTMR-1:0] sel_lo, sel_cnt, sel_ctl, sel_eoi, sel_sts, sel_hi;
  logic [CW-1:0]   rd_val;
  logic            g_eoi;

  always_comb begin
    for (int i = 0; i < NTMR; i++) begin
      sel_lo[i]  = addr == AW'(i*STRIDE);
      sel_cnt[i] = addr == AW'(i*STRIDE + 4);
      sel_ctl[i] = addr == AW'(i*STRIDE + 8);
      sel_eoi[i] = addr == AW'(i*STRIDE + 12);
      sel_sts[i] = addr == AW'(i*STRIDE + 16);
      sel_hi[i]  = addr == AW'(HI_BASE + 4*i);
      en_v[i]    = ctrl[i][0];
      mode_v[i]  = ctrl[i][1];
      msk_v[i]   = ctrl[i][2];
      pwm_v[i]   = ctrl[i][3];
      expire[i]  = ctrl[i][0] && (cnt[i] == '0);
    end
  end

  assign g_eoi   = rd_en && (addr == AW'(A_EOI));
  assign masked  = raw & ~msk_v;
  assign irq     = |masked;
  assign pwm_out = phase & en_v & pwm_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_lo <= '0;
      ld_hi <= '0;
      cnt   <= '0;
      ctrl  <= '0;
      phase <= '0;
      raw   <= '0;
    end else begin
      for (int i = 0; i < NTMR; i++) begin
        if (wr_en && sel_lo[i]) ld_lo[i] <= wdata;
        if (wr_en && sel_hi[i]) ld_hi[i] <= wdata;
        if (wr_en && sel_ctl[i]) ctrl[i] <= wdata[CTLW-1:0];

        if (wr_en && sel_ctl[i] && wdata[0] && !en_v[i]) begin
          cnt[i]   <= ld_lo[i];
          phase[i] <= 1'b0;
        end else if (expire[i]) begin
          if (pwm_v[i]) begin
            cnt[i]   <= phase[i] ? ld_lo[i] : ld_hi[i];
            phase[i] <= ~phase[i];
          end else if (mode_v[i]) begin
            cnt[i] <= ld_lo[i];
          end else begin
            cnt[i] <= '1;
          end
        end else if (en_v[i]) begin
          cnt[i] <= cnt[i] - CW'(1);
        end

        if (expire[i]) raw[i] <= 1'b1;
        else if (g_eoi || (rd_en && sel_eoi[i])) raw[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_val = '0;
    if (addr == AW'(A_ISTS)) rd_val = CW'(masked);
    if (addr == AW'(A_RAW))  rd_val = CW'(raw);
    if (addr == AW'(A_VER))  rd_val = VERSION;
    for (int i = 0; i < NTMR; i++) begin
      if (sel_lo[i])  rd_val = ld_lo[i];
      if (sel_cnt[i]) rd_val = cnt[i];
      if (sel_ctl[i]) rd_val = CW'(ctrl[i]);
      if (sel_sts[i]) rd_val = CW'(masked[i]);
      if (sel_hi[i])  rd_val = ld_hi[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) rdata <= rd_val;
  end
endmodule

// File: rtl/pwm_timer_bank_chk.sv
module pwm_timer_bank_chk #(
  parameter int NTMR = 8,
  parameter int CW = 32,
  parameter int AW = 8,
  parameter logic [CW-1:0] VERSION = 32'h5054_0102
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    rd_en,
  input logic [AW-1:0]           addr,
  input logic [CW-1:0]           rdata,
  input logic [NTMR-1:0]         pwm_out,
  input logic                    irq,
  input logic [NTMR-1:0]         en_v,
  input logic [NTMR-1:0]         pwm_v,
  input logic [NTMR-1:0][CW-1:0] cnt
);
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (pwm_out == '0 && irq == 1'b0 && rdata == '0);
    end
  end

  assert_version_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == AW'('hAC)) |=> rdata == VERSION);

  assert_eoi_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == AW'('hA4)) |=> rdata == '0);

  for (genvar i = 0; i < NTMR; i++) begin : g_t
    assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_v[i]) |-> !pwm_out[i]);

    assert_toggle_at_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (en_v[i] && pwm_v[i] && $past(en_v[i] && pwm_v[i]) && (pwm_out[i] != $past(pwm_out[i])))
        |-> $past(cnt[i]) == '0);

    assert_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !en_v[i] |=> (en_v[i] || $stable(cnt[i])));

    assert_eoi_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == AW'(i*'h14 + 12)) |=> rdata == '0);
  end
endmodule

bind pwm_timer_bank pwm_timer_bank_chk #(
  .NTMR(NTMR), .CW(CW), .AW(AW), .VERSION(VERSION)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .rdata(rdata),
  .pwm_out(pwm_out), .irq(irq), .en_v(en_v), .pwm_v(pwm_v), .cnt(cnt)
);

// File: tb/tb_pwm_timer_bank.sv
module tb_pwm_timer_bank;
  localparam logic [31:0] EXP_VER = 32'h5054_0102;

  logic        clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic [7:0]  pwm_out;
  logic        irq;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  pwm_timer_bank dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out), .irq(irq));

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  function automatic logic [7:0] base(input int t); return 8'(t*20); endfunction
  function automatic logic [7:0] hiad(input int t); return 8'('hB0 + 4*t); endfunction
  function automatic logic exp_pwm(input int k, input int l, input int h);
    return (k % (l + h + 2)) > l;
  endfunction
  function automatic logic [31:0] exp_user(input int k, input int l);
    return 32'(l - (k % (l + 1)));
  endfunction
  function automatic logic [31:0] exp_free(input int k, input int l);
    return (k <= l) ? 32'(l - k) : 32'hFFFF_FFFF - 32'(k - l - 1);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_en = 1; addr = a;
    @(posedge clk); @(negedge clk);
    rd_en = 0; d = rdata;
  endtask

  task automatic start_t(input int t, input int l, input int h, input logic [3:0] c, output int st);
    wr(base(t), 32'(l));
    wr(hiad(t), 32'(h));
    wr(base(t) + 8'd8, {28'd0, c});
    st = cyc;
  endtask

  task automatic quiet();
    logic [31:0] d;
    for (int t = 0; t < 8; t++) wr(base(t) + 8'd8, 32'd0);
    rd(8'hA4, d);
  endtask

  task automatic wave(input int t, input int l, input int h, input int st, input int n, input string req);
    bit bad = 0; logic a = 0, e = 0;
    for (int j = 0; j < n; j++) begin
      if (!bad && pwm_out[t] !== exp_pwm(cyc - st, l, h)) begin
        bad = 1; a = pwm_out[t]; e = exp_pwm(cyc - st, l, h);
      end
      @(negedge clk);
    end
    chk(!bad, req, 32'(a), 32'(e));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2;
    int st, kk;
    int ll[8], hh[8], ss[8];
    bit bad[8];
    d = $urandom(32'h0bad_5eed);

    repeat (3) @(negedge clk);
    chk(pwm_out == 0 && irq == 0, "R1 outputs in reset", {23'd0, irq, pwm_out}, 0);
    rst_n = 1;
    @(negedge clk);
    rd(8'h00, d);  chk(d == 0, "R1 low reload reset", d, 0);
    rd(8'hB0, d);  chk(d == 0, "R1 high reload reset", d, 0);
    rd(8'h08, d);  chk(d == 0, "R1 control reset", d, 0);
    rd(8'hA8, d);  chk(d == 0, "R1 raw reset", d, 0);

    // R2 / R3 directed waveforms
    start_t(0, 4, 2, 4'b1011, st);
    chk(pwm_out[0] == 0, "R2 output low at enable", 32'(pwm_out[0]), 0);
    wave(0, 4, 2, st, 40, "R2 R3 L=4 H=2 waveform");
    quiet();
    start_t(3, 0, 0, 4'b1011, st);
    wave(3, 0, 0, st, 20, "R3 L=0 H=0 one-cycle phases");
    quiet();
    start_t(1, 6, 0, 4'b1001, st);
    wave(1, 6, 0, st, 30, "R5 PWM ignores mode bit, R3 H=0");
    quiet();

    // R4 user reload count
    start_t(2, 5, 0, 4'b0011, st);
    repeat (9) @(negedge clk);
    kk = cyc - st; rd(base(2) + 8'd4, d);
    chk(d == exp_user(kk, 5), "R4 user reload count", d, exp_user(kk, 5));
    chk(pwm_out[2] == 0, "R4 no waveform without PWM bit", 32'(pwm_out[2]), 0);
    quiet();

    // R5 free-running wrap
    start_t(2, 2, 0, 4'b0001, st);
    repeat (5) @(negedge clk);
    kk = cyc - st; rd(base(2) + 8'd4, d);
    chk(d == exp_free(kk, 2), "R5 free-running wrap", d, exp_free(kk, 2));
    quiet();

    // R11 reload rewritten while running
    start_t(1, 3, 0, 4'b0011, st);
    wr(base(1), 32'd10);
    repeat (6) @(negedge clk);
    kk = cyc - st; rd(base(1) + 8'd4, d);
    chk(d == 32'(10 - (kk - 4)), "R11 new reload used at next reload", d, 32'(10 - (kk - 4)));
    quiet();

    // R6 disable freezes and holds low
    start_t(4, 2, 2, 4'b1011, st);
    repeat (4) @(negedge clk);
    wr(base(4) + 8'd8, 32'b1010);
    rd(base(4) + 8'd4, d);
    repeat (5) @(negedge clk);
    rd(base(4) + 8'd4, d2);
    chk(d == d2, "R6 counter frozen", d2, d);
    chk(pwm_out[4] == 0, "R6 output held low", 32'(pwm_out[4]), 0);
    quiet();

    // R7 raw / masked / irq, R8 per-timer clear
    start_t(2, 1, 0, 4'b0011, st);
    repeat (4) @(negedge clk);
    wr(base(2) + 8'd8, 32'd0);
    rd(8'hA8, d);  chk(d == 32'h4, "R7 raw bit set", d, 32'h4);
    rd(base(2) + 8'h10, d); chk(d == 1, "R7 per-timer status", d, 1);
    chk(irq == 1, "R7 irq asserted", 32'(irq), 1);
    wr(base(2) + 8'd8, 32'b0100);
    rd(base(2) + 8'h10, d); chk(d == 0, "R7 masked per-timer status", d, 0);
    rd(8'hA0, d);  chk(d == 0, "R7 masked global status", d, 0);
    chk(irq == 0, "R7 irq masked", 32'(irq), 0);
    rd(8'hA8, d);  chk(d == 32'h4, "R7 raw kept under mask", d, 32'h4);
    rd(base(2) + 8'h0C, d); chk(d == 0, "R8 clear read returns zero", d, 0);
    rd(8'hA8, d);  chk(d == 0, "R8 per-timer clear", d, 0);
    quiet();

    // R8 expiry and clear in same cycle
    start_t(5, 0, 0, 4'b1011, st);
    repeat (3) @(negedge clk);
    rd(base(5) + 8'h0C, d);
    rd(8'hA8, d);
    chk(d[5] == 1, "R8 expiry wins over clear", 32'(d[5]), 1);
    quiet();

    // R9 global clear
    start_t(0, 0, 0, 4'b0011, st);
    start_t(1, 0, 0, 4'b0011, st);
    repeat (2) @(negedge clk);
    wr(base(0) + 8'd8, 0); wr(base(1) + 8'd8, 0);
    rd(8'hA8, d);  chk(d == 32'h3, "R9 two raw bits set", d, 32'h3);
    rd(8'hA4, d);  chk(d == 0, "R9 global clear returns zero", d, 0);
    rd(8'hA8, d);  chk(d == 0, "R9 all raw bits cleared", d, 0);

    // R10 version and ignored writes
    rd(base(0) + 8'd4, d2);
    wr(8'hAC, 32'h1234_5678); wr(8'hA8, 32'hFF); wr(8'hA0, 32'hFF);
    wr(base(0) + 8'd4, 32'h55); wr(8'hF0, 32'hDEAD);
    rd(8'hAC, d);  chk(d == EXP_VER, "R10 version", d, EXP_VER);
    rd(8'hA8, d);  chk(d == 0, "R10 raw not writable", d, 0);
    rd(base(0) + 8'd4, d); chk(d == d2, "R10 count not writable", d, d2);

    // R12 map and control width
    wr(base(6) + 8'd8, 32'hFFFF_FFF6);
    rd(base(6) + 8'd8, d); chk(d == 32'h6, "R12 control keeps four bits", d, 32'h6);
    wr(hiad(7), 32'hA5A5_0007); wr(base(7), 32'h0000_1234);
    rd(hiad(7), d); chk(d == 32'hA5A5_0007, "R12 high reload address", d, 32'hA5A5_0007);
    rd(base(7), d); chk(d == 32'h1234, "R12 low reload address", d, 32'h1234);
    quiet();

    // random: all timers at once
    for (int t = 0; t < 8; t++) begin
      ll[t] = int'($urandom_range(0, 9)); hh[t] = int'($urandom_range(0, 9)); bad[t] = 0;
      start_t(t, ll[t], hh[t], 4'b1011, ss[t]);
    end
    for (int j = 0; j < 80; j++) begin
      for (int t = 0; t < 8; t++)
        if (pwm_out[t] !== exp_pwm(cyc - ss[t], ll[t], hh[t])) bad[t] = 1;
      @(negedge clk);
    end
    for (int t = 0; t < 8; t++) chk(!bad[t], "R2 R3 random concurrent waveform", 32'(bad[t]), 0);
    quiet();

    // random: count reads in user mode
    for (int r = 0; r < 6; r++) begin
      int t = int'($urandom_range(0, 7));
      int l = int'($urandom_range(0, 15));
      start_t(t, l, 0, 4'b0011, st);
      repeat (int'($urandom_range(0, 30))) @(negedge clk);
      kk = cyc - st; rd(base(t) + 8'd4, d);
      chk(d == exp_user(kk, l), "R4 random count read", d, exp_user(kk, l));
      quiet();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule